// File: doc/BRIEF.md
# Bidirectional General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port that sits on a simple register bus. Software sets each pin as an input or an output on its own. Software sets the value driven on output pins through an output latch. Software reads the pin levels back through a separate path. The latch is stored apart from the pins, so a read-modify-write of the latch works on the intended data even when a pin is held at another level from outside.

There are three registers at consecutive addresses:

- Address 0 is the port view. A read returns the synchronised pin levels. A write loads the output latch.
- Address 1 is the latch view. A read returns the stored latch value. A write loads the output latch.
- Address 2 is the direction register. A bit of 1 makes that pin an input, with its driver off.

Two mode inputs can take the pins away from the registers:

- An external memory bus takes the pins whenever its disable control is low.
- A parallel slave-port function takes the pins whenever its mode bit is high.

While either mode holds the pins, this block drives no output enable and no output value. Register writes are still accepted during that time, and they take effect on the pads when the mode is released.

Top module: `bidir_io_port`

## Requirements
- R1: Reset state. After reset, every direction bit is 1, the output latch is 0 and every bit of `pad_oe` is 0.
- R2: Output enable. While the port owns the pins, `pad_oe[i]` is the inverse of direction bit i, so a direction bit of 1 means input with the driver off.
- R3: Output value. While the port owns the pins, `pad_out` equals the output latch.
- R4: Latch access. A write with `bus_addr` = 0 or `bus_addr` = 1 loads `bus_wdata` into the latch. A read at `bus_addr` = 1 returns the latch value and never the pin levels.
- R5: Direction access. A write at `bus_addr` = 2 loads the direction register. A read at `bus_addr` = 2 returns the direction register.
- R6: Pin read. A read at `bus_addr` = 0 returns `pad_in` as sampled through two flops, so a pin change appears on `bus_rdata` after the second rising clock edge.
- R7: External bus override. While `xbus_off` is 0, `pad_oe` and `pad_out` are all zero.
- R8: Slave-port override. While `slave_mode` is 1, `pad_oe` and `pad_out` are all zero.
- R9: Writes during override. Register writes made during an override are kept, and they reach `pad_oe` and `pad_out` once the override is released.
- R10: Unmapped address. A read at `bus_addr` = 3 returns zero, and a write there changes no register.
- R11: No write. While `bus_wr_en` is 0, the latch and the direction register keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (2) | Register address: 0 port, 1 latch, 2 direction |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | WIDTH (8) | Write data |
| bus_rdata | output | WIDTH (8) | Combinational read data for `bus_addr` |
| pad_in | input | WIDTH (8) | Pin levels from the pads (asynchronous) |
| pad_oe | output | WIDTH (8) | Per-pin output enable, 1 means drive |
| pad_out | output | WIDTH (8) | Per-pin output value |
| xbus_off | input | 1 | 1 disables the external memory bus, letting the port own the pins |
| slave_mode | input | 1 | 1 hands the pins to the parallel slave-port function |

## Verification
A corrupted latch shows up on `pad_out` at the next clock edge for every pin set as an output, and on a read at address 1 in the same cycle. A wrong direction bit shows up at once as a flipped `pad_oe` bit. A synchroniser fault shows up as a port read that is off by one or more cycles, so the pin-read check samples both after the first edge and after the second. An override leak shows up as a nonzero pad output while a mode input holds the pins, which is visible in the very cycle the mode changes.

// File: rtl/bidir_io_pkg.sv
`timescale 1ns/1ps
package bidir_io_pkg;

    // Register selector decoded from the bus address.
    typedef enum logic [1:0] {
        SEL_PIN  = 2'd0,
        SEL_LAT  = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Map a bus address of any width onto a register selector.
    function automatic reg_sel_e decode_addr(input logic [31:0] addr);
        case (addr)
            32'd0:   return SEL_PIN;
            32'd1:   return SEL_LAT;
            32'd2:   return SEL_DIR;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/bidir_io_sync.sv
`timescale 1ns/1ps
module bidir_io_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pin_level
);

    // Two-stage synchroniser state, plus a warm-up count used only by the checker.
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] held;
        logic [1:0]       warm;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = pad_in;
        s_d.held = s_q.meta;
        if (s_q.warm != 2'd2) begin
            s_d.warm = s_q.warm + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pin_level = s_q.held;

    // R6: the read level lags the pad by exactly two edges once two edges have passed since reset.
    assert_sync_two_stage_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.warm == 2'd2) |-> (pin_level == $past(pad_in, 2)));

endmodule

// File: rtl/bidir_io_regs.sv
`timescale 1ns/1ps
module bidir_io_regs
    import bidir_io_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_sel_e         sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_bits,
    output logic [WIDTH-1:0] lat_bits
);

    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] lat;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (sel)
                SEL_PIN, SEL_LAT: r_d.lat = wdata;
                SEL_DIR:          r_d.dir = wdata;
                default:          ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.dir <= '1;
            r_q.lat <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dir_bits = r_q.dir;
    assign lat_bits = r_q.lat;

    // R4: a write at the port or latch address lands in the latch.
    assert_latch_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == SEL_PIN || sel == SEL_LAT)) |=> (lat_bits == $past(wdata)));

    // R5: a write at the direction address lands in the direction register.
    assert_dir_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DIR) |=> (dir_bits == $past(wdata)));

    // R11: without a write strobe both registers hold.
    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(dir_bits) && $stable(lat_bits)));

    // R10: a write at the unmapped address touches nothing.
    assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NONE) |=> ($stable(dir_bits) && $stable(lat_bits)));

endmodule

// File: rtl/bidir_io_drive.sv
`timescale 1ns/1ps
module bidir_io_drive #(
    parameter int WIDTH = 8
) (
    input  logic             port_owns,
    input  logic [WIDTH-1:0] dir_bits,
    input  logic [WIDTH-1:0] lat_bits,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out
);

    // One output cell per pin. While a mode holds the pins, the cell drives nothing.
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        always_comb begin
            pad_oe[i]  = port_owns & ~dir_bits[i];
            pad_out[i] = port_owns &  lat_bits[i];
        end
    end

endmodule

// File: rtl/bidir_io_port.sv
`timescale 1ns/1ps
module bidir_io_port
    import bidir_io_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out,
    input  logic              xbus_off,
    input  logic              slave_mode
);

    localparam int AW32 = (ADDR_W > 32) ? 32 : ADDR_W;

    reg_sel_e         sel;
    logic [WIDTH-1:0] dir_bits;
    logic [WIDTH-1:0] lat_bits;
    logic [WIDTH-1:0] pin_level;
    logic             port_owns;

    always_comb begin
        sel       = decode_addr(32'(bus_addr[AW32-1:0]));
        port_owns = xbus_off & ~slave_mode;
    end

    bidir_io_sync #(.WIDTH(WIDTH)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_in    (pad_in),
        .pin_level (pin_level)
    );

    bidir_io_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .wr_en    (bus_wr_en),
        .wdata    (bus_wdata),
        .dir_bits (dir_bits),
        .lat_bits (lat_bits)
    );

    bidir_io_drive #(.WIDTH(WIDTH)) u_drive (
        .port_owns (port_owns),
        .dir_bits  (dir_bits),
        .lat_bits  (lat_bits),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out)
    );

    // Read mux: the port view and the latch view stay apart.
    always_comb begin
        unique case (sel)
            SEL_PIN: bus_rdata = pin_level;
            SEL_LAT: bus_rdata = lat_bits;
            SEL_DIR: bus_rdata = dir_bits;
            default: bus_rdata = '0;
        endcase
    end

    // R7: the external bus owns the pins while it is enabled.
    assert_xbus_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !xbus_off |-> (pad_oe == '0 && pad_out == '0));

    // R8: the slave-port mode owns the pins.
    assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> (pad_oe == '0 && pad_out == '0));

    // R2: the output enable tracks the inverted direction bits while the port owns the pins.
    assert_oe_from_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        port_owns |-> (pad_oe == ~dir_bits));

    // R10: unmapped reads return zero.
    assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (bus_rdata == '0));

endmodule

// File: tb/bidir_io_port_tb.sv
`timescale 1ns/1ps
module bidir_io_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr_en = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe;
    logic [7:0] pad_out;
    logic       xbus_off = 1'b1;
    logic       slave_mode = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bidir_io_port u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr_en  (bus_wr_en),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pad_in     (pad_in),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .xbus_off   (xbus_off),
        .slave_mode (slave_mode)
    );

    typedef struct packed {
        logic       wr;
        logic [1:0] addr;
        logic [7:0] wdata;
        logic       xoff;
        logic       slave;
        logic [7:0] pins;
        logic [7:0] exp_rd;
        logic [7:0] exp_oe;
        logic [7:0] exp_out;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 2'd2, 8'h0F, 1'b1, 1'b0, 8'hA5, 8'h0F, 8'hF0, 8'h00}, // R5 R2
        '{1'b1, 2'd1, 8'h3C, 1'b1, 1'b0, 8'h00, 8'h3C, 8'hF0, 8'h3C}, // R4 R3
        '{1'b1, 2'd0, 8'h5A, 1'b1, 1'b0, 8'h81, 8'h81, 8'hF0, 8'h5A}, // R4 R6
        '{1'b0, 2'd1, 8'hFF, 1'b1, 1'b0, 8'h81, 8'h5A, 8'hF0, 8'h5A}, // R4 R11
        '{1'b1, 2'd3, 8'hFF, 1'b1, 1'b0, 8'h81, 8'h00, 8'hF0, 8'h5A}, // R10
        '{1'b1, 2'd1, 8'h77, 1'b0, 1'b0, 8'h81, 8'h77, 8'h00, 8'h00}, // R7 R9
        '{1'b1, 2'd2, 8'h00, 1'b1, 1'b1, 8'h81, 8'h00, 8'h00, 8'h00}, // R8 R9
        '{1'b0, 2'd2, 8'h00, 1'b1, 1'b0, 8'h3C, 8'h00, 8'hFF, 8'h77}, // R9 R2 R3
        '{1'b1, 2'd2, 8'hFF, 1'b1, 1'b0, 8'h3C, 8'hFF, 8'h00, 8'h77}, // R5 R2
        '{1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 8'hC3, 8'hC3, 8'h00, 8'h77}  // R6
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        bus_wr_en  = v.wr;
        bus_addr   = v.addr;
        bus_wdata  = v.wdata;
        xbus_off   = v.xoff;
        slave_mode = v.slave;
        pad_in     = v.pins;
        @(posedge clk);
        #1 bus_wr_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_addr = 2'd2; #0.5;
        check("R1 dir reset", bus_rdata, 8'hFF);
        bus_addr = 2'd1; #0.5;
        check("R1 latch reset", bus_rdata, 8'h00);
        check("R1 oe reset", pad_oe, 8'h00);

        // Vector walk
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i]);
            check($sformatf("vec %0d rdata R4/R5/R6/R10", i), bus_rdata, VECS[i].exp_rd);
            check($sformatf("vec %0d oe R2/R7/R8/R9", i), pad_oe, VECS[i].exp_oe);
            check($sformatf("vec %0d out R3/R7/R8/R9", i), pad_out, VECS[i].exp_out);
        end

        // R6: the pin change is not visible after one edge, and is visible after two
        @(negedge clk);
        bus_addr = 2'd0;
        pad_in   = 8'h5A;
        @(negedge clk);
        check("R6 one edge", bus_rdata, 8'hC3);
        @(negedge clk);
        check("R6 two edges", bus_rdata, 8'h5A);

        // R11: data on the bus without a strobe leaves the latch alone
        bus_addr  = 2'd1;
        bus_wdata = 8'hAA;
        repeat (2) @(negedge clk);
        check("R11 latch held", bus_rdata, 8'h77);
        check("R11 out held", pad_out, 8'h77);

        // R1: a reset mid-run restores the defaults
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_addr = 2'd2; #0.5;
        check("R1 dir after reset", bus_rdata, 8'hFF);
        check("R1 out after reset", pad_out, 8'h00);
        check("R1 oe after reset", pad_oe, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule